// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the byte-wide configuration front end of a multi-function I/O controller. It decodes two addresses on a simple I/O write/read bus: an index port and a data port. The configuration space stays closed until a fixed four-byte key has been written to the index port in order. While the space is open, a write to the index port selects a configuration register, and accesses to the data port read or write that register.

Registers below index 0x30 are global. They hold a logical device number, a 16-bit identifier and a revision. Registers from 0x30 upward are banked, and the logical device number decides which device's bank they reach. Each device bank has an enable flag and a 16-bit I/O base address, and both drive outputs to the attached functions. A dedicated command in the data port closes the configuration space again.

Top module: `cfg_keyed_port`

## Requirements
- R1: After reset the space is closed, the device number is 0, every device enable is 0 and every base address is 0x0000.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index port in this order opens the space. The next access is already served.
- R3: An index-port byte that does not match the expected key byte resets the key match. If that byte equals 0x87, it counts as the first key byte.
- R4: While the space is closed, data-port writes change nothing and reads of either port return 0xFF.
- R5: While the space is open, every index-port write loads the index. Data-port accesses use the latest index, and an index-port read returns it.
- R6: A data write of 0x02 while the index is 0x02 closes the space. A different value at index 0x02, or 0x02 at a different index, leaves it open. Register contents are kept.
- R7: Index 0x20 reads the identifier high byte and 0x21 the low byte. Index 0x22 reads the revision in bits 3:0 with bits 7:4 zero. Writes to these indices have no effect.
- R8: Index 0x07 is a read/write device number that selects the bank for indices 0x30 and above.
- R9: In the selected bank, index 0x30 bit 0 is the enable and reads back as 0x00 or 0x01. Index 0x60 is the base address bits 15:8 and 0x61 bits 7:0. These values drive `dev_active[n]` and `dev_base[16n+15:16n]`.
- R10: A device number of NUM_DEV or more selects an empty bank: banked reads return 0x00 and banked writes change no device.
- R11: Reads of unimplemented indices return 0x00.
- R12: Bus accesses to any address other than the two ports change no state. Reads at such addresses return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| cfg_open | output | 1 | Configuration space is open |
| dev_active | output | NUM_DEV | Per-device enable |
| dev_base | output | 16*NUM_DEV | Per-device base address, device n in bits 16n+15:16n |

## Verification
The bench breaks the key after three correct bytes. If a detector skipped the reset, it would open on a later partial key. The bench also replays 0x87 as the breaking byte. A detector that returned to its idle position would then need an extra byte and stay closed. The exit command is tested with each half alone. A decoder that looked only at the value or only at the index would close the space too early, and banked writes to an out-of-range device number would change a real device if the device number were truncated instead of compared in full.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int KEY_LEN = 4;
  localparam int KPOS_W  = $clog2(KEY_LEN);

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VAL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BANK    = 8'h30;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] FLOAT_BYTE  = 8'hFF;

  // Expected byte at each key position
  function automatic logic [7:0] key_byte(input logic [KPOS_W-1:0] pos);
    case (pos)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction

  // Next match position after a byte; a wrong byte may restart the match
  function automatic logic [KPOS_W-1:0] key_step(input logic [KPOS_W-1:0] pos,
                                                 input logic [7:0] b);
    if (b == key_byte(pos))      key_step = pos + 1'b1;
    else if (b == key_byte('0))  key_step = KPOS_W'(1);
    else                         key_step = '0;
  endfunction

  // Global register read mux
  function automatic logic [7:0] glob_read(input logic [7:0] idx,
                                           input logic [7:0] ldn,
                                           input logic [15:0] id,
                                           input logic [3:0] rev);
    case (idx)
      IDX_LDN:   glob_read = ldn;
      IDX_ID_HI: glob_read = id[15:8];
      IDX_ID_LO: glob_read = id[7:0];
      IDX_REV:   glob_read = {4'h0, rev};
      default:   glob_read = 8'h00;
    endcase
  endfunction

  // Per-device register read mux
  function automatic logic [7:0] bank_read(input logic [7:0] idx,
                                           input logic act,
                                           input logic [15:0] base);
    case (idx)
      IDX_ACT:     bank_read = {7'd0, act};
      IDX_BASE_HI: bank_read = base[15:8];
      IDX_BASE_LO: bank_read = base[7:0];
      default:     bank_read = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_wr,
  input  logic [7:0] wbyte,
  output logic       key_match
);

  logic [KPOS_W-1:0] pos_q;

  // Last key byte accepted in its slot
  assign key_match = byte_wr && (pos_q == KPOS_W'(KEY_LEN - 1)) &&
                     (wbyte == key_byte(pos_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos_q <= '0;
    else if (key_match) pos_q <= '0;
    else if (byte_wr)   pos_q <= key_step(pos_q, wbyte);
  end

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfgport_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hC3A7,
  parameter logic [3:0]  CHIP_REV = 4'h5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx_q,
  output logic [7:0] ldn_q,
  output logic [7:0] glob_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (data_wr && idx_q == IDX_LDN) ldn_q <= wdata;
    end
  end

  assign glob_rdata = glob_read(idx_q, ldn_q, CHIP_ID, CHIP_REV);

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfgport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        act_q,
  output logic [15:0] base_q,
  output logic [7:0]  rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_ACT:     act_q        <= wdata[0];
        IDX_BASE_HI: base_q[15:8] <= wdata;
        IDX_BASE_LO: base_q[7:0]  <= wdata;
        default:     ;
      endcase
    end
  end

  assign rdata = bank_read(idx, act_q, base_q);

endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 'h2E,
  parameter int unsigned DATA_PORT  = 'h2F,
  parameter int unsigned NUM_DEV    = 4,
  parameter logic [15:0] CHIP_ID    = 16'hC3A7,
  parameter logic [3:0]  CHIP_REV   = 4'h5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  cfg_open,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [16*NUM_DEV-1:0] dev_base
);

  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(INDEX_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_PORT);

  logic       at_index, at_data;
  logic       idx_wr_locked, idx_wr_open, data_wr_open;
  logic       key_match, exit_cmd, cfg_open_q;
  logic [7:0] idx_q, ldn_q, glob_rdata, bank_rdata, cfg_rdata;
  logic [NUM_DEV-1:0] bank_wr;
  logic [7:0] bank_rd [NUM_DEV];

  assign at_index      = (bus_addr == IDX_A);
  assign at_data       = (bus_addr == DAT_A);
  assign idx_wr_locked = bus_wr && at_index && !cfg_open_q;
  assign idx_wr_open   = bus_wr && at_index && cfg_open_q;
  assign data_wr_open  = bus_wr && at_data && cfg_open_q;
  assign exit_cmd      = data_wr_open && (idx_q == IDX_EXIT) &&
                         (bus_wdata == EXIT_VAL);

  cfg_key_detect u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_wr   (idx_wr_locked),
    .wbyte     (bus_wdata),
    .key_match (key_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_open_q <= 1'b0;
    else if (key_match) cfg_open_q <= 1'b1;
    else if (exit_cmd)  cfg_open_q <= 1'b0;
  end
  assign cfg_open = cfg_open_q;

  cfg_global_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr_open),
    .data_wr    (data_wr_open),
    .wdata      (bus_wdata),
    .idx_q      (idx_q),
    .ldn_q      (ldn_q),
    .glob_rdata (glob_rdata)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    assign bank_wr[g] = data_wr_open && (idx_q >= IDX_BANK) &&
                        (ldn_q == 8'(g));
    cfg_dev_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr[g]),
      .idx    (idx_q),
      .wdata  (bus_wdata),
      .act_q  (dev_active[g]),
      .base_q (dev_base[16*g +: 16]),
      .rdata  (bank_rd[g])
    );
  end

  // Out-of-range device numbers fall through to zero
  always_comb begin
    bank_rdata = 8'h00;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldn_q == 8'(i)) bank_rdata = bank_rd[i];
  end

  assign cfg_rdata = (idx_q < IDX_BANK) ? glob_rdata : bank_rdata;

  always_comb begin
    bus_rdata = FLOAT_BYTE;
    if (bus_rd && cfg_open_q) begin
      if (at_index)     bus_rdata = idx_q;
      else if (at_data) bus_rdata = cfg_rdata;
    end
  end

endmodule

// File: rtl/cfg_keyed_port_chk.sv
module cfg_keyed_port_chk
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 'h2E,
  parameter int unsigned DATA_PORT  = 'h2F,
  parameter int unsigned NUM_DEV    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [7:0]            bus_rdata,
  input logic                  cfg_open,
  input logic                  key_match,
  input logic                  exit_cmd,
  input logic [7:0]            idx_q,
  input logic [7:0]            ldn_q,
  input logic [NUM_DEV-1:0]    bank_wr,
  input logic [NUM_DEV-1:0]    dev_active,
  input logic [16*NUM_DEV-1:0] dev_base
);

  logic at_port;
  assign at_port = (bus_addr == ADDR_W'(INDEX_PORT)) ||
                   (bus_addr == ADDR_W'(DATA_PORT));

  // R2
  unlock_follows_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_match |=> cfg_open);

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(key_match));

  // R6
  exit_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_cmd |=> !cfg_open);

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_wr) |=> ($stable(dev_active) && $stable(dev_base) &&
                               $stable(ldn_q)));

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_rd) |-> (bus_rdata == FLOAT_BYTE));

  // R9
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));

  // R10
  empty_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && bus_addr == ADDR_W'(DATA_PORT) &&
     idx_q >= IDX_BANK && ldn_q >= 8'(NUM_DEV))
    |=> ($stable(dev_active) && $stable(dev_base)));

  // R12
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !at_port) |=> ($stable(cfg_open) && $stable(idx_q) &&
                              $stable(ldn_q) && $stable(dev_active) &&
                              $stable(dev_base)));

endmodule

bind cfg_keyed_port cfg_keyed_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
  .NUM_DEV(NUM_DEV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .cfg_open   (cfg_open),
  .key_match  (key_match),
  .exit_cmd   (exit_cmd),
  .idx_q      (idx_q),
  .ldn_q      (ldn_q),
  .bank_wr    (bank_wr),
  .dev_active (dev_active),
  .dev_base   (dev_base)
);

// File: tb/cfg_keyed_port_test.sv
module cfg_keyed_port_test;

  localparam int          NDEV = 4;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;
  localparam logic [15:0] ID   = 16'hC3A7;
  localparam logic [3:0]  REV  = 4'h5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              cfg_open;
  logic [NDEV-1:0]   dev_active;
  logic [16*NDEV-1:0] dev_base;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_keyed_port #(.ADDR_W(16), .INDEX_PORT('h2E), .DATA_PORT('h2F),
                   .NUM_DEV(NDEV), .CHIP_ID(ID), .CHIP_REV(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_open(cfg_open), .dev_active(dev_active), .dev_base(dev_base));

  task automatic check(input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #5 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(IDXP, i); wr(DATP, d);
  endtask

  task automatic cfg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(IDXP, i); rd(DATP, d);
  endtask

  task automatic unlock();
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    check("R1 closed", cfg_open, 0);
    check("R1 active", dev_active, 0);
    check("R1 base", dev_base, 0);
    rd(DATP, d); check("R1 read", d, 8'hFF);
  endtask

  task automatic t_locked();
    logic [7:0] d;
    wr(DATP, 8'h01);
    rd(IDXP, d); check("R4 index read", d, 8'hFF);
    rd(DATP, d); check("R4 data read", d, 8'hFF);
    check("R4 no write", dev_active, 0);
  endtask

  task automatic t_key();
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h00);
    wr(IDXP, 8'h55);
    @(negedge clk); check("R3 broken key", cfg_open, 0);
    // 0x87 breaks a partial match and restarts it
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h87); wr(IDXP, 8'h01);
    wr(IDXP, 8'h55);
    @(negedge clk); check("R3 partial", cfg_open, 0);
    wr(IDXP, 8'h55);
    @(negedge clk); check("R3 restart open", cfg_open, 1);
    // close, then the plain key
    cfg_wr(8'h02, 8'h02);
    @(negedge clk); check("R6 closed", cfg_open, 0);
    unlock();
    @(negedge clk); check("R2 open", cfg_open, 1);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    cfg_rd(8'h20, d); check("R7 id hi", d, ID[15:8]);
    cfg_rd(8'h21, d); check("R7 id lo", d, ID[7:0]);
    cfg_rd(8'h22, d); check("R7 rev", d, {4'h0, REV});
    cfg_wr(8'h20, 8'h00);
    rd(DATP, d); check("R7 read only", d, ID[15:8]);
  endtask

  task automatic t_index();
    logic [7:0] d;
    wr(IDXP, 8'h20); wr(IDXP, 8'h21);
    rd(DATP, d); check("R5 latest index", d, ID[7:0]);
    rd(IDXP, d); check("R5 index read", d, 8'h21);
  endtask

  task automatic t_banks();
    logic [7:0] d;
    cfg_wr(8'h07, 8'h01);
    cfg_rd(8'h07, d); check("R8 ldn", d, 8'h01);
    cfg_wr(8'h30, 8'hFF);
    @(negedge clk); check("R9 active", dev_active, 4'b0010);
    cfg_rd(8'h30, d); check("R9 act read", d, 8'h01);
    cfg_wr(8'h60, 8'h12); cfg_wr(8'h61, 8'h34);
    @(negedge clk); check("R9 base", dev_base[31:16], 16'h1234);
    check("R9 other base", dev_base[15:0], 16'h0000);
    cfg_wr(8'h07, 8'h02);
    cfg_rd(8'h30, d); check("R8 bank switch", d, 8'h00);
    cfg_wr(8'h61, 8'hCD);
    @(negedge clk); check("R8 bank2 base", dev_base[47:32], 16'h00CD);
  endtask

  task automatic t_unknown();
    logic [7:0] d;
    cfg_wr(8'h07, 8'h09);
    cfg_wr(8'h30, 8'h01); cfg_wr(8'h60, 8'hAB);
    @(negedge clk);
    check("R10 act", dev_active, 4'b0010);
    check("R10 base", dev_base, {16'h0, 16'h00CD, 16'h1234, 16'h0});
    cfg_rd(8'h30, d); check("R10 read act", d, 8'h00);
    cfg_rd(8'h60, d); check("R10 read base", d, 8'h00);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    cfg_wr(8'h07, 8'h01);
    cfg_rd(8'h05, d); check("R11 idx 05", d, 8'h00);
    cfg_rd(8'h2F, d); check("R11 idx 2F", d, 8'h00);
    cfg_rd(8'h45, d); check("R11 idx 45", d, 8'h00);
  endtask

  task automatic t_other();
    logic [7:0] d;
    wr(IDXP, 8'h07);
    wr(16'h0080, 8'h03); wr(16'h012F, 8'h03);
    rd(DATP, d); check("R12 ldn kept", d, 8'h01);
    rd(16'h0080, d); check("R12 other read", d, 8'hFF);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    cfg_wr(8'h02, 8'h03);
    @(negedge clk); check("R6 wrong value", cfg_open, 1);
    cfg_wr(8'h07, 8'h02);
    @(negedge clk); check("R6 wrong index", cfg_open, 1);
    cfg_wr(8'h02, 8'h02);
    @(negedge clk); check("R6 exit", cfg_open, 0);
    rd(DATP, d); check("R6 locked read", d, 8'hFF);
    check("R6 kept", dev_active, 4'b0010);
    unlock();
    cfg_rd(8'h07, d); check("R6 ldn kept", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_locked();
    t_key();
    t_ids();
    t_index();
    t_banks();
    t_unknown();
    t_unimpl();
    t_other();
    t_exit();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule